// File: doc/BRIEF.md
# Multiplexed Logical Channel Link

This block moves words for several independent logical channels across one shared physical link between two neighbouring cells. On the sending side, each channel offers words through its own valid/ready port. On the receiving side, each channel has its own queue, and the consumer drains that queue through a dedicated pop port. Channels are allocated by a static enable mask, and a channel that is not allocated never moves data.

The shared bus is time-multiplexed by a fixed rotation. Each clock gives one slot to the next allocated channel in ascending order, wrapping around at the top. A slot that its owner cannot use, because it has nothing to send or no credit, stays empty. It is never handed to another channel, so every allocated channel keeps a fixed share of the bus.

The sender holds one free-slot counter per channel. It sends on a channel only while that channel's counter is non-zero. When a word is popped from a receive queue, a tagged credit returns to the sender, so one stalled consumer blocks only its own channel.

Top module: `lchan_mux_link`

## Requirements
- R1: During and right after reset, the bus and the credit return are idle, every receive queue is empty, the slot sits on channel 0, and every free-slot counter holds DEPTH (8). With all channels allocated, `sendReady` therefore reads 4'b0001.
- R2: The slot advances once per clock to the next allocated channel in ascending index order, wrapping from the highest index to the lowest.
- R3: At most one `sendReady` bit is high at any time. That bit belongs to the current slot owner, which must be allocated and must hold a non-zero free-slot count.
- R4: A slot whose owner has no valid word or no credit carries nothing, and the bus stays idle for that cycle. As a result, a lone active channel among N allocated ones transfers exactly every N cycles.
- R5: A channel can have at most DEPTH (8) words sent but not yet credited back. After that, it gets no further transfer until a credit returns.
- R6: Popping a non-empty queue makes `creditValid` high for one cycle with `creditTag` equal to the channel index, in the cycle after the pop edge. The sender's counter rises at the next edge, and one more word may then be sent.
- R7: A word accepted at a clock edge appears on the bus during the following cycle, with `linkValid` = 1, `linkTag` = channel index and `linkData` = the word.
- R8: Each receive queue returns its channel's words in the order they were sent. `rxData` shows the head word while `rxNotEmpty` is high.
- R9: No receive queue ever receives a word while it already holds DEPTH words.
- R10: A channel whose enable bit is 0 never places a word on the bus.
- R11: When every allocated channel always has data and its consumer pops at once, the bus carries a word every cycle. Each allocated channel gets exactly one slot per rotation.
- R12: A pop on an empty queue has no effect. It produces no credit and leaves that channel's credit count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanEn | input | NUM_CH | Static allocation mask, one bit per channel |
| sendValid | input | NUM_CH | Per-channel send request |
| sendData | input | NUM_CH*DATA_W | Per-channel send words, channel c at bits c*DATA_W upward |
| sendReady | output | NUM_CH | Per-channel acceptance; a word moves when valid and ready are both high |
| linkValid | output | 1 | Physical bus word valid |
| linkTag | output | TAG_W | Channel tag of the bus word |
| linkData | output | DATA_W | Data of the bus word |
| creditValid | output | 1 | Credit return pulse |
| creditTag | output | TAG_W | Channel whose queue freed a slot |
| rxPop | input | NUM_CH | Per-channel receive-queue pop |
| rxData | output | NUM_CH*DATA_W | Per-channel head words |
| rxNotEmpty | output | NUM_CH | Per-channel queue holds at least one word |

## Verification
The main function is driven with every one of the sixteen allocation masks under full load with immediate draining. Sparse masks such as 4'b0101 or 4'b1000 show whether the rotation skips unallocated channels and wraps correctly, while the full mask shows whether every channel gets one slot per turn with no idle cycles.

A single active channel among four allocated ones separates a rotation that keeps the idle slots empty from one that lends them to busy channels. A channel that sends without any pops separates correct credit accounting from both an early and a late stall, and a single pop then shows whether exactly one credit comes back. Pops on an empty queue, followed by a burst, show whether spurious credits leak into the counters.

// File: rtl/lchan_pkg.sv
package lchan_pkg;

  // Widest channel tag the strobe bundle can carry.
  localparam int TAG_MAX_W = 8;

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic                 xfer;  // a word is accepted at this edge
    logic [TAG_MAX_W-1:0] ch;    // channel owning the current slot
  } sendStb_t;

endpackage

// File: rtl/lchan_rxq.sv
module lchan_rxq #(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 8,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  output logic [DATA_W-1:0] headData,
  output logic              notEmpty,
  output logic              full
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  count;
  logic              popOk;

  assign popOk    = popEn && (count != '0);
  assign notEmpty = (count != '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushEn) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushEn) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (pushEn && !popOk)      count <= count + 1'b1;
      else if (popOk && !pushEn) count <= count - 1'b1;
    end
  end

  // R12: popping an empty queue leaves it empty
  a_r12_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && (count == '0) && !pushEn) |=> (count == '0));

endmodule

// File: rtl/lchan_ctrl.sv
module lchan_ctrl
  import lchan_pkg::*;
#(
  parameter  int NUM_CH = 4,
  parameter  int DEPTH  = 8,
  localparam int TAG_W  = $clog2(NUM_CH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic [NUM_CH-1:0] sendValid,
  output logic [NUM_CH-1:0] sendReady,
  input  logic              creditValid,
  input  logic [TAG_W-1:0]  creditTag,
  output sendStb_t          stb
);

  logic [TAG_W-1:0] curSlot;
  logic [TAG_W-1:0] nextSlot;
  logic [TAG_W-1:0] probe;
  logic             found;
  int               scanJ;

  // Next allocated channel after the current slot, ascending with wrap.
  always_comb begin
    nextSlot = curSlot;
    found    = 1'b0;
    probe    = '0;
    scanJ    = 0;
    for (int i = 1; i <= NUM_CH; i++) begin
      scanJ = int'(curSlot) + i;
      if (scanJ >= NUM_CH) scanJ = scanJ - NUM_CH;
      probe = TAG_W'(scanJ);
      if (!found && chanEn[probe]) begin
        nextSlot = probe;
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curSlot <= '0;
    else       curSlot <= nextSlot;
  end

  // One free-slot counter per channel.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [CNT_W-1:0] freeCnt;
    logic             take;
    logic             give;

    assign sendReady[c] = chanEn[c] && (curSlot == TAG_W'(c)) && (freeCnt != '0);
    assign take         = sendValid[c] && sendReady[c];
    assign give         = creditValid && (creditTag == TAG_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              freeCnt <= CNT_W'(DEPTH);
      else if (take && !give) freeCnt <= freeCnt - 1'b1;
      else if (give && !take) freeCnt <= freeCnt + 1'b1;
    end

    // R5: outstanding words never exceed the far queue depth
    a_r5_credit_bound: assert property (@(posedge clk) disable iff (!rstN)
      freeCnt <= CNT_W'(DEPTH));
  end

  assign stb.xfer = |(sendValid & sendReady);
  assign stb.ch   = TAG_MAX_W'(curSlot);

  // R3: at most one channel may be accepted per slot
  a_r3_single_owner: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sendReady));

  // R2: with a stable nonzero mask the slot lands on an allocated channel
  a_r2_rotate: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn != '0) ##1 (chanEn == $past(chanEn)) |-> chanEn[curSlot]);

endmodule

// File: rtl/lchan_dpath.sv
module lchan_dpath
  import lchan_pkg::*;
#(
  parameter  int NUM_CH = 4,
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 8,
  localparam int TAG_W  = $clog2(NUM_CH),
  localparam int PEND_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH*DATA_W-1:0] sendData,
  input  sendStb_t                 stb,
  input  logic [NUM_CH-1:0]        rxPop,
  output logic                     linkValid,
  output logic [TAG_W-1:0]         linkTag,
  output logic [DATA_W-1:0]        linkData,
  output logic                     creditValid,
  output logic [TAG_W-1:0]         creditTag,
  output logic [NUM_CH*DATA_W-1:0] rxData,
  output logic [NUM_CH-1:0]        rxNotEmpty
);

  logic [DATA_W-1:0] selWord;
  logic [NUM_CH-1:0] pushEn;
  logic [NUM_CH-1:0] popDone;
  logic [NUM_CH-1:0] qFull;
  logic [NUM_CH-1:0] pendNz;
  logic              retValid;
  logic [TAG_W-1:0]  retTag;
  logic [TAG_W-1:0]  lastRet;
  logic [TAG_W-1:0]  probe;
  int                scanJ;

  // Word of the slot owner.
  always_comb begin
    selWord = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (stb.ch == TAG_MAX_W'(i)) selWord = sendData[i*DATA_W +: DATA_W];
    end
  end

  // Physical bus register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkValid <= 1'b0;
      linkTag   <= '0;
      linkData  <= '0;
    end else begin
      linkValid <= stb.xfer;
      if (stb.xfer) begin
        linkTag  <= stb.ch[TAG_W-1:0];
        linkData <= selWord;
      end
    end
  end

  // Per-channel receive queues and pending-credit counters.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_rx
    logic [PEND_W-1:0] pend;
    logic              sent;

    assign pushEn[c]  = linkValid && (linkTag == TAG_W'(c));
    assign popDone[c] = rxPop[c] && rxNotEmpty[c];
    assign sent       = retValid && (retTag == TAG_W'(c));
    assign pendNz[c]  = (pend != '0);

    lchan_rxq #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
    ) i_rxq (
      .clk      (clk),
      .rstN     (rstN),
      .pushEn   (pushEn[c]),
      .pushData (linkData),
      .popEn    (rxPop[c]),
      .headData (rxData[c*DATA_W +: DATA_W]),
      .notEmpty (rxNotEmpty[c]),
      .full     (qFull[c])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 pend <= '0;
      else if (popDone[c] && !sent) pend <= pend + 1'b1;
      else if (sent && !popDone[c]) pend <= pend - 1'b1;
    end

    // R9: the credit scheme never lets a word reach a full queue
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
      pushEn[c] |-> !qFull[c]);
  end

  // Return one credit per cycle, rotating priority after the last one sent.
  always_comb begin
    retValid = 1'b0;
    retTag   = lastRet;
    probe    = '0;
    scanJ    = 0;
    for (int i = 1; i <= NUM_CH; i++) begin
      scanJ = int'(lastRet) + i;
      if (scanJ >= NUM_CH) scanJ = scanJ - NUM_CH;
      probe = TAG_W'(scanJ);
      if (!retValid && pendNz[probe]) begin
        retValid = 1'b1;
        retTag   = probe;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lastRet <= TAG_W'(NUM_CH - 1);
    else if (retValid) lastRet <= retTag;
  end

  assign creditValid = retValid;
  assign creditTag   = retTag;

endmodule

// File: rtl/lchan_mux_link.sv
module lchan_mux_link
  import lchan_pkg::*;
#(
  parameter  int NUM_CH = 4,
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 8,
  localparam int TAG_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        chanEn,
  input  logic [NUM_CH-1:0]        sendValid,
  input  logic [NUM_CH*DATA_W-1:0] sendData,
  output logic [NUM_CH-1:0]        sendReady,
  output logic                     linkValid,
  output logic [TAG_W-1:0]         linkTag,
  output logic [DATA_W-1:0]        linkData,
  output logic                     creditValid,
  output logic [TAG_W-1:0]         creditTag,
  input  logic [NUM_CH-1:0]        rxPop,
  output logic [NUM_CH*DATA_W-1:0] rxData,
  output logic [NUM_CH-1:0]        rxNotEmpty
);

  sendStb_t stb;

  lchan_ctrl #(
    .NUM_CH (NUM_CH),
    .DEPTH  (DEPTH)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .chanEn      (chanEn),
    .sendValid   (sendValid),
    .sendReady   (sendReady),
    .creditValid (creditValid),
    .creditTag   (creditTag),
    .stb         (stb)
  );

  lchan_dpath #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .sendData    (sendData),
    .stb         (stb),
    .rxPop       (rxPop),
    .linkValid   (linkValid),
    .linkTag     (linkTag),
    .linkData    (linkData),
    .creditValid (creditValid),
    .creditTag   (creditTag),
    .rxData      (rxData),
    .rxNotEmpty  (rxNotEmpty)
  );

  // R10: only allocated channels appear on the bus
  a_r10_alloc_only: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> chanEn[linkTag]);

endmodule

// File: tb/test_lchan_mux_link.sv
module test_lchan_mux_link;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int TAG_W  = 2;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic [NUM_CH-1:0]        chanEn = '0;
  logic [NUM_CH-1:0]        sendValid = '0;
  logic [NUM_CH*DATA_W-1:0] sendData = '0;
  logic [NUM_CH-1:0]        sendReady;
  logic                     linkValid;
  logic [TAG_W-1:0]         linkTag;
  logic [DATA_W-1:0]        linkData;
  logic                     creditValid;
  logic [TAG_W-1:0]         creditTag;
  logic [NUM_CH-1:0]        rxPop = '0;
  logic [NUM_CH*DATA_W-1:0] rxData;
  logic [NUM_CH-1:0]        rxNotEmpty;

  always #5 clk = ~clk;

  lchan_mux_link #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .DEPTH(DEPTH)) i_lchan_mux_link (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .sendValid(sendValid), .sendData(sendData),
    .sendReady(sendReady), .linkValid(linkValid), .linkTag(linkTag), .linkData(linkData),
    .creditValid(creditValid), .creditTag(creditTag), .rxPop(rxPop), .rxData(rxData),
    .rxNotEmpty(rxNotEmpty));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // stimulus flags and model state
  bit        autoPop, fullLoad, gapCheck;
  logic [3:0] validMask;
  bit        popReq [NUM_CH];
  bit        popEmpty [NUM_CH];
  bit        willXfer [NUM_CH];
  int        drvSeq [NUM_CH], busSeq [NUM_CH], popSeq [NUM_CH], occ [NUM_CH];
  int        xferCnt [NUM_CH], popCnt [NUM_CH], credCnt [NUM_CH], lastSeen [NUM_CH];
  int        cyc, prevTag;
  bit        prevLV;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nextEn(input int t, input logic [3:0] m);
    for (int i = 1; i <= NUM_CH; i++) if (m[(t + i) % NUM_CH]) return (t + i) % NUM_CH;
    return t;
  endfunction

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic applyReset(input logic [3:0] mask);
    @(negedge clk);
    #2;
    rstN = 1'b0;
    chanEn = mask;
    autoPop = 0; fullLoad = 0; gapCheck = 0; validMask = '0;
    cyc = 0; prevLV = 0; prevTag = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      popReq[c] = 0; popEmpty[c] = 0; willXfer[c] = 0;
      drvSeq[c] = 0; busSeq[c] = 0; popSeq[c] = 0; occ[c] = 0;
      xferCnt[c] = 0; popCnt[c] = 0; credCnt[c] = 0; lastSeen[c] = -1;
    end
    waitCyc(2);
    rstN = 1'b1;
  endtask

  // monitor and driver, acting at the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      sendValid <= '0;
      rxPop     <= '0;
    end else begin
      cyc++;
      if (linkValid) begin
        int t;
        t = int'(linkTag);
        chk(chanEn[t] == 1'b1, "R10 unallocated channel on bus", t, -1);
        chk(linkData == {4'(t), 12'(busSeq[t])}, "R7 bus word and tag", int'(linkData),
            int'({4'(t), 12'(busSeq[t])}));
        busSeq[t]++;
        xferCnt[t]++;
        if (gapCheck && lastSeen[t] >= 0)
          chk(cyc - lastSeen[t] == $countones(chanEn), "R4 slot spacing per channel",
              cyc - lastSeen[t], $countones(chanEn));
        if (fullLoad && prevLV)
          chk(t == nextEn(prevTag, chanEn), "R2 rotation order", t, nextEn(prevTag, chanEn));
        lastSeen[t] = cyc;
      end else if (fullLoad && prevLV) begin
        chk(0, "R11 idle cycle under full load", 0, 1);
      end
      prevLV  = linkValid;
      prevTag = int'(linkTag);
      if (creditValid) credCnt[creditTag]++;
      for (int c = 0; c < NUM_CH; c++) begin
        bit doPop;
        doPop = (autoPop || popReq[c]) && rxNotEmpty[c];
        if (doPop) begin
          chk(rxData[c*DATA_W +: DATA_W] == {4'(c), 12'(popSeq[c])}, "R8 queue order",
              int'(rxData[c*DATA_W +: DATA_W]), int'({4'(c), 12'(popSeq[c])}));
          popSeq[c]++;
          popCnt[c]++;
        end
        rxPop[c] = doPop || popEmpty[c];
        if (linkValid && int'(linkTag) == c) begin
          occ[c] = occ[c] + 1 - int'(doPop);
          chk(occ[c] <= DEPTH, "R9 queue overflow", occ[c], DEPTH);
        end else begin
          occ[c] = occ[c] - int'(doPop);
        end
        if (willXfer[c]) drvSeq[c]++;
        sendValid[c] = validMask[c];
        sendData[c*DATA_W +: DATA_W] = {4'(c), 12'(drvSeq[c])};
      end
      #1;
      for (int c = 0; c < NUM_CH; c++) willXfer[c] = sendValid[c] && sendReady[c];
      chk(($countones(sendReady) <= 1) && ((sendReady & ~chanEn) == '0),
          "R3 single allocated owner", int'(sendReady), int'(sendReady & chanEn));
    end
  end

  initial begin
    // R1 reset state
    applyReset(4'hF);
    chk(linkValid == 1'b0, "R1 bus idle after reset", int'(linkValid), 0);
    chk(creditValid == 1'b0, "R1 no credit after reset", int'(creditValid), 0);
    chk(rxNotEmpty == '0, "R1 queues empty after reset", int'(rxNotEmpty), 0);
    chk(sendReady == 4'b0001, "R1 slot on channel 0 with credit", int'(sendReady), 1);

    // R11 full load over every allocation mask (R2, R4, R7, R8, R10 checked in the monitor)
    for (int m = 0; m < 16; m++) begin
      int k, minC, maxC;
      applyReset(4'(m));
      autoPop = 1; fullLoad = 1; gapCheck = 1; validMask = 4'hF;
      waitCyc(60);
      fullLoad = 0; validMask = '0;
      waitCyc(20);
      k = $countones(4'(m));
      minC = 1000; maxC = 0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (m[c]) begin
          if (xferCnt[c] < minC) minC = xferCnt[c];
          if (xferCnt[c] > maxC) maxC = xferCnt[c];
          chk(xferCnt[c] >= 60 / k - 2, "R11 share per channel", xferCnt[c], 60 / k - 2);
        end else begin
          chk(xferCnt[c] == 0, "R10 unallocated channel moved data", xferCnt[c], 0);
        end
        chk(popCnt[c] == xferCnt[c], "R8 every sent word delivered", popCnt[c], xferCnt[c]);
        chk(credCnt[c] == popCnt[c], "R6 one credit per pop", credCnt[c], popCnt[c]);
      end
      if (k > 0) chk(maxC - minC <= 1, "R11 equal slots per rotation", maxC - minC, 1);
    end

    // R5 credit exhaustion, then R6 single credit return
    applyReset(4'hF);
    validMask = 4'b0100;
    waitCyc(60);
    chk(xferCnt[2] == DEPTH, "R5 stall after DEPTH words", xferCnt[2], DEPTH);
    chk(occ[2] == DEPTH, "R5 queue holds DEPTH words", occ[2], DEPTH);
    chk(rxNotEmpty[2] == 1'b1, "R8 not-empty flag", int'(rxNotEmpty[2]), 1);
    chk(credCnt[2] == 0, "R6 no credit without pop", credCnt[2], 0);
    popReq[2] = 1;
    waitCyc(1);
    popReq[2] = 0;
    waitCyc(1);
    chk(creditValid == 1'b1 && creditTag == 2'd2, "R6 credit pulse after pop",
        int'({creditValid, creditTag}), int'({1'b1, 2'd2}));
    waitCyc(1);
    chk(creditValid == 1'b0, "R6 credit pulse lasts one cycle", int'(creditValid), 0);
    waitCyc(30);
    chk(xferCnt[2] == DEPTH + 1, "R6 one extra word per credit", xferCnt[2], DEPTH + 1);
    chk(credCnt[2] == 1, "R6 single credit returned", credCnt[2], 1);
    autoPop = 1; validMask = '0;
    waitCyc(30);
    chk(popCnt[2] == DEPTH + 1, "R8 drained in order", popCnt[2], DEPTH + 1);

    // R4 idle slots stay idle
    applyReset(4'hF);
    autoPop = 1; gapCheck = 1; validMask = 4'b0010;
    waitCyc(41);
    chk(xferCnt[1] >= 9 && xferCnt[1] <= 10, "R4 lone channel one slot in four", xferCnt[1], 10);
    chk(xferCnt[0] + xferCnt[2] + xferCnt[3] == 0, "R4 idle slots not reassigned",
        xferCnt[0] + xferCnt[2] + xferCnt[3], 0);

    // R12 pop on empty
    applyReset(4'hF);
    popEmpty[3] = 1;
    waitCyc(4);
    popEmpty[3] = 0;
    waitCyc(2);
    chk(credCnt[3] == 0, "R12 no credit from empty pop", credCnt[3], 0);
    chk(rxNotEmpty == '0, "R12 queues still empty", int'(rxNotEmpty), 0);
    validMask = 4'b1000;
    waitCyc(50);
    chk(xferCnt[3] == DEPTH, "R12 credit count unchanged", xferCnt[3], DEPTH);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL run timeout on all requirements actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule